// File: doc/BRIEF.md
# Main Contactor Release Sequencer

This block owns the main contactor output of a motor drive and decides when it may open. While the contactor is closed, any shutdown condition starts a release. A shutdown condition is a missing run permissive, an active drive fault, or a low regulator-run enable. During the release the contactor is held closed until the motor current has decayed below a small fraction of its rated limit, so the contacts never break a loaded circuit. If the current does not decay in time, a timeout opens the contactor anyway.

An independent interlock watches the run permissive on its own. When the permissive stays absent for a fixed number of millisecond ticks, the interlock removes the contactor output and the gate-power output at once, whatever the sequencer is doing. It also drives the sequencer to its open state. After a release the contactor stays open until a fresh close request arrives while no shutdown condition is present.

The current limit is computed from a rated-current value and an integer overload ratio. It is captured when the parameters are loaded, so the comparison in the release path costs one comparator and no multiplier.

Top module: `contactor_release_seq`

## Requirements
- R1: During and right after reset, `seq_state` reads 0 (OPEN), `contactor_on` is 0 and `gate_pwr_on` is 1.
- R2: In OPEN, a cycle with `close_req` high and no shutdown condition moves `seq_state` to 1 (ENERGIZED) at the next edge, and `contactor_on` goes to 1.
- R3: A close request is ignored while any shutdown condition is present. The shutdown conditions are `run_perm` low, `drive_fault` high, or `reg_run` low. `seq_state` stays 0.
- R4: In ENERGIZED, any single shutdown condition moves `seq_state` to 2 (DRAINING) at the next edge, and `contactor_on` stays 1.
- R5: The limit is floor(`rated_cur` × `ovl_ratio` × 2 / 100), captured on a cycle with `param_load` high. In DRAINING, `cur_fb` strictly below the limit opens the contactor at the next edge. `cur_fb` equal to the limit keeps it in DRAINING.
- R6: In DRAINING, the contactor opens after TIMEOUT_MS edges that have `ms_tick` high, regardless of current. The edge that enters DRAINING does not count, and edges without a tick do not count.
- R7: Once in OPEN, the block stays in OPEN even after every shutdown condition clears, until a new close request arrives.
- R8: When `run_perm` has been low for PERM_LOSS_MS consecutive ticked edges, `contactor_on` and `gate_pwr_on` both drop in the same cycle, whatever the state. `seq_state` becomes 0 at the following edge.
- R9: `gate_pwr_on` returns to 1 one edge after `run_perm` goes high again, and `contactor_on` stays 0.
- R10: In ENERGIZED, a current below the limit with no shutdown condition has no effect, and `seq_state` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| run_perm | input | 1 | Run permissive, high when present |
| drive_fault | input | 1 | Drive fault active |
| reg_run | input | 1 | Regulator-run enable |
| close_req | input | 1 | Request to close the contactor |
| param_load | input | 1 | Capture the current-limit parameters |
| rated_cur | input | CUR_W | Rated motor current |
| ovl_ratio | input | OVL_W | Integer overload ratio |
| cur_fb | input | CUR_W | Current-feedback magnitude |
| contactor_on | output | 1 | Main contactor drive |
| gate_pwr_on | output | 1 | Gate-power enable |
| seq_state | output | 2 | Sequencer state: 0 OPEN, 1 ENERGIZED, 2 DRAINING |

## Verification
The hardest situation to reach from the ports is an interlock trip while the sequencer is still in DRAINING. At default sizes the sequencer timeout always expires before the interlock. The bench therefore builds the block with an interlock window shorter than the timeout. It starts a release with a drive fault and holds the current above the limit, then removes the permissive. Both outputs must fall on the exact predicted cycle while the state still reads DRAINING. The limit boundary is swept over several rated values and overload ratios, and each of the three shutdown causes is tried in rotation.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        ST_OPEN      = 2'd0,
        ST_ENERGIZED = 2'd1,
        ST_DRAINING  = 2'd2
    } seq_state_e;

    // Percentage of the rated limit below which the contacts may open.
    localparam int unsigned DRAIN_PCT = 2;

    function automatic logic shutdown_needed(
        input logic perm_ok,
        input logic fault,
        input logic run_en
    );
        return (!perm_ok) || fault || (!run_en);
    endfunction

    function automatic int unsigned ctr_width(input int unsigned limit,
                                              input int unsigned floor_w);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < floor_w) ? floor_w : w;
    endfunction

endpackage

// File: rtl/crs_threshold.sv
module crs_threshold #(
    parameter int unsigned CUR_W = 16,
    parameter int unsigned OVL_W = 4,
    parameter int unsigned PCT   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CUR_W-1:0] rated,
    input  logic [OVL_W-1:0] ovl,
    output logic [CUR_W-1:0] limit
);
    localparam int unsigned PROD_W = CUR_W + OVL_W + 8;
    localparam logic [PROD_W-1:0] SAT = PROD_W'({CUR_W{1'b1}});

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        prod = PROD_W'(rated) * PROD_W'(ovl) * PROD_W'(PCT);
        quot = prod / PROD_W'(100);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= '0;
        end else if (load) begin
            limit <= (quot > SAT) ? {CUR_W{1'b1}} : quot[CUR_W-1:0];
        end
    end
endmodule

// File: rtl/crs_perm_interlock.sv
module crs_perm_interlock #(
    parameter int unsigned PERM_LOSS_MS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic perm_ok,
    output logic trip
);
    localparam int unsigned PW = crs_pkg::ctr_width(PERM_LOSS_MS, 10);
    localparam logic [PW-1:0] LAST = PW'(PERM_LOSS_MS - 1);

    logic [PW-1:0] lost_cnt;

    always_ff @(posedge clk) begin
        if (rst || perm_ok) begin
            lost_cnt <= '0;
            trip     <= 1'b0;
        end else if (tick && !trip) begin
            if (lost_cnt == LAST) begin
                trip <= 1'b1;
            end else begin
                lost_cnt <= lost_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/crs_release_fsm.sv
module crs_release_fsm #(
    parameter int unsigned CUR_W      = 16,
    parameter int unsigned TIMEOUT_MS = 300
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  shutdown,
    input  logic                  force_open,
    input  logic                  close_req,
    input  logic [CUR_W-1:0]      cur_fb,
    input  logic [CUR_W-1:0]      limit,
    output crs_pkg::seq_state_e   state
);
    import crs_pkg::*;

    localparam int unsigned TW = ctr_width(TIMEOUT_MS, 9);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_MS - 1);

    seq_state_e    nxt;
    logic [TW-1:0] wait_cnt;
    logic          decayed;
    logic          expired;

    always_comb begin
        decayed = cur_fb < limit;
        expired = tick && (wait_cnt == LAST);
        nxt     = state;
        unique case (state)
            ST_OPEN:      if (close_req && !shutdown) nxt = ST_ENERGIZED;
            ST_ENERGIZED: if (shutdown)               nxt = ST_DRAINING;
            ST_DRAINING:  if (decayed || expired)     nxt = ST_OPEN;
            default:                                  nxt = ST_OPEN;
        endcase
        if (force_open) nxt = ST_OPEN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OPEN;
            wait_cnt <= '0;
        end else begin
            state <= nxt;
            if (state != ST_DRAINING) begin
                wait_cnt <= '0;
            end else if (tick && !expired) begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/contactor_release_seq.sv
module contactor_release_seq #(
    parameter int unsigned CUR_W        = 16,
    parameter int unsigned OVL_W        = 4,
    parameter int unsigned TIMEOUT_MS   = 300,
    parameter int unsigned PERM_LOSS_MS = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             run_perm,
    input  logic             drive_fault,
    input  logic             reg_run,
    input  logic             close_req,
    input  logic             param_load,
    input  logic [CUR_W-1:0] rated_cur,
    input  logic [OVL_W-1:0] ovl_ratio,
    input  logic [CUR_W-1:0] cur_fb,
    output logic             contactor_on,
    output logic             gate_pwr_on,
    output logic [1:0]       seq_state
);
    import crs_pkg::*;

    logic             rel_cond;
    logic             il_trip;
    logic [CUR_W-1:0] thr_q;
    seq_state_e       state;

    assign rel_cond = shutdown_needed(run_perm, drive_fault, reg_run);

    crs_threshold #(
        .CUR_W (CUR_W),
        .OVL_W (OVL_W),
        .PCT   (DRAIN_PCT)
    ) u_thr (
        .clk   (clk),
        .rst   (rst),
        .load  (param_load),
        .rated (rated_cur),
        .ovl   (ovl_ratio),
        .limit (thr_q)
    );

    crs_perm_interlock #(
        .PERM_LOSS_MS (PERM_LOSS_MS)
    ) u_ilk (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .perm_ok (run_perm),
        .trip    (il_trip)
    );

    crs_release_fsm #(
        .CUR_W      (CUR_W),
        .TIMEOUT_MS (TIMEOUT_MS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tick       (ms_tick),
        .shutdown   (rel_cond),
        .force_open (il_trip),
        .close_req  (close_req),
        .cur_fb     (cur_fb),
        .limit      (thr_q),
        .state      (state)
    );

    // The interlock gates both outputs directly, bypassing the sequencer.
    assign contactor_on = (state != ST_OPEN) && !il_trip;
    assign gate_pwr_on  = !il_trip;
    assign seq_state    = state;
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
    parameter int unsigned CUR_W      = 16,
    parameter int unsigned TIMEOUT_MS = 300
) (
    input logic             clk,
    input logic             rst,
    input logic             ms_tick,
    input logic             close_req,
    input logic             rel_cond,
    input logic             il_trip,
    input logic [1:0]       seq_state,
    input logic [CUR_W-1:0] cur_fb,
    input logic [CUR_W-1:0] thr_q,
    input logic             contactor_on,
    input logic             gate_pwr_on
);
    localparam int unsigned CW = $clog2(TIMEOUT_MS + 2);

    logic [CW-1:0] drain_ticks;

    always_ff @(posedge clk) begin
        if (rst || seq_state != 2'd2) begin
            drain_ticks <= '0;
        end else if (ms_tick) begin
            drain_ticks <= drain_ticks + 1'b1;
        end
    end

    a_r1_reset_open: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seq_state == 2'd0 && !contactor_on));

    a_r2_close: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0 && close_req && !rel_cond && !il_trip) |=> seq_state == 2'd1);

    a_r3_close_blocked: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0 && rel_cond) |=> seq_state == 2'd0);

    a_r4_start_drain: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && rel_cond && !il_trip) |=> seq_state == 2'd2);

    a_r5_decay_open: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2 && cur_fb < thr_q) |=> seq_state == 2'd0);

    a_r6_timeout_bound: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2) |-> (drain_ticks < CW'(TIMEOUT_MS)));

    a_r7_stay_open: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0 && !close_req) |=> seq_state == 2'd0);

    a_r8_gate_implies_contactor: assert property (@(posedge clk) disable iff (rst)
        !gate_pwr_on |-> !contactor_on);

    a_r8_trip_opens_seq: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_pwr_on) |=> seq_state == 2'd0);
endmodule

bind contactor_release_seq crs_checker #(
    .CUR_W      (CUR_W),
    .TIMEOUT_MS (TIMEOUT_MS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ms_tick      (ms_tick),
    .close_req    (close_req),
    .rel_cond     (rel_cond),
    .il_trip      (il_trip),
    .seq_state    (seq_state),
    .cur_fb       (cur_fb),
    .thr_q        (thr_q),
    .contactor_on (contactor_on),
    .gate_pwr_on  (gate_pwr_on)
);

// File: tb/sim_contactor_release_seq.sv
module sim_contactor_release_seq;
    localparam int CW = 12;
    localparam int OW = 4;
    localparam int T  = 20;
    localparam int P  = 12;

    logic clk = 1'b0;
    logic rst, ms_tick, run_perm, drive_fault, reg_run, close_req, param_load;
    logic [CW-1:0] rated_cur, cur_fb;
    logic [OW-1:0] ovl_ratio;
    logic contactor_on, gate_pwr_on;
    logic [1:0] seq_state;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    contactor_release_seq #(
        .CUR_W (CW), .OVL_W (OW), .TIMEOUT_MS (T), .PERM_LOSS_MS (P)
    ) u0 (
        .clk (clk), .rst (rst), .ms_tick (ms_tick), .run_perm (run_perm),
        .drive_fault (drive_fault), .reg_run (reg_run), .close_req (close_req),
        .param_load (param_load), .rated_cur (rated_cur), .ovl_ratio (ovl_ratio),
        .cur_fb (cur_fb), .contactor_on (contactor_on), .gate_pwr_on (gate_pwr_on),
        .seq_state (seq_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic energize();
        close_req = 1'b1;
        step();
        close_req = 1'b0;
        check("R2 state", int'(seq_state), 1);
        check("R2 contactor", int'(contactor_on), 1);
    endtask

    initial begin
        int thr;
        int idx;
        int rv[4];
        rv = '{50, 137, 999, 4095};
        rst = 1'b1; ms_tick = 1'b1; run_perm = 1'b1; drive_fault = 1'b0;
        reg_run = 1'b1; close_req = 1'b0; param_load = 1'b0;
        rated_cur = '0; ovl_ratio = '0; cur_fb = '0;
        repeat (3) step();
        check("R1 state in reset", int'(seq_state), 0);
        rst = 1'b0;
        step();
        check("R1 state", int'(seq_state), 0);
        check("R1 contactor", int'(contactor_on), 0);
        check("R1 gate", int'(gate_pwr_on), 1);

        // R3: close request while a fault is active
        drive_fault = 1'b1; close_req = 1'b1;
        step();
        check("R3 state", int'(seq_state), 0);
        close_req = 1'b0; drive_fault = 1'b0;
        step();

        // R5 / R4 / R10 / R7 sweep over limits and shutdown causes
        idx = 0;
        foreach (rv[i]) begin
            for (int ov = 1; ov <= 3; ov++) begin
                thr = (rv[i] * ov * 2) / 100;
                rated_cur = CW'(rv[i]); ovl_ratio = OW'(ov); param_load = 1'b1;
                step();
                param_load = 1'b0;
                energize();
                cur_fb = CW'(thr - 1);
                step();
                check("R10 energized ignores low current", int'(seq_state), 1);
                cur_fb = CW'(thr);
                case (idx % 3)
                    0: drive_fault = 1'b1;
                    1: reg_run = 1'b0;
                    default: run_perm = 1'b0;
                endcase
                step();
                check("R4 draining", int'(seq_state), 2);
                check("R4 contactor held", int'(contactor_on), 1);
                step();
                check("R5 equal keeps draining", int'(seq_state), 2);
                cur_fb = CW'(thr - 1);
                step();
                check("R5 below opens", int'(seq_state), 0);
                check("R5 contactor off", int'(contactor_on), 0);
                drive_fault = 1'b0; reg_run = 1'b1; run_perm = 1'b1;
                step();
                step();
                check("R7 stays open", int'(seq_state), 0);
                check("R7 contactor off", int'(contactor_on), 0);
                cur_fb = '0;
                idx++;
            end
        end

        // R6: timeout with a pause in ticks
        energize();
        cur_fb = '1; reg_run = 1'b0;
        step();
        check("R6 enter draining", int'(seq_state), 2);
        ms_tick = 1'b0;
        repeat (5) step();
        check("R6 no tick no count", int'(seq_state), 2);
        ms_tick = 1'b1;
        repeat (T - 1) step();
        check("R6 one tick short", int'(seq_state), 2);
        step();
        check("R6 timeout opens", int'(seq_state), 0);
        check("R6 contactor off", int'(contactor_on), 0);
        reg_run = 1'b1;
        step();

        // R8: permissive lost while draining
        energize();
        drive_fault = 1'b1;
        step();
        check("R8 draining before loss", int'(seq_state), 2);
        run_perm = 1'b0;
        repeat (P - 1) step();
        check("R8 contactor before trip", int'(contactor_on), 1);
        check("R8 gate before trip", int'(gate_pwr_on), 1);
        step();
        check("R8 contactor at trip", int'(contactor_on), 0);
        check("R8 gate at trip", int'(gate_pwr_on), 0);
        check("R8 state still draining", int'(seq_state), 2);
        step();
        check("R8 state forced open", int'(seq_state), 0);

        // R9: permissive returns
        run_perm = 1'b1; drive_fault = 1'b0;
        step();
        check("R9 gate restored", int'(gate_pwr_on), 1);
        check("R9 contactor stays off", int'(contactor_on), 0);
        energize();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule